// File: doc/BRIEF.md
# Conditional Block-Floating-Point Scaling Controller

This block manages one common exponent for an entire fixed-point transform sequence that a butterfly datapath processes stage by stage. Butterfly results reach it with two guard bits above the 16-bit word. For each result it works out how many bits the value has grown past the signed 16-bit range (0, 1 or 2), and it keeps the largest such growth seen during the current stage. When the stage is over and the arithmetic pipeline has emptied, that maximum becomes the shift for the next stage and is added to the shared exponent. A stage in which nothing grew therefore causes no shift.

The operands fetched in the next stage go through the block's read path, which shifts them right arithmetically by the latched amount as they arrive. This keeps the sequence in range without any extra pass over memory. After the final stage the same path serves as the output stage: a result pass through it leaves 16-bit words, and the host reads the exponent next to them. For an inverse transform, a second exponent output is already reduced by log2 of the length to account for the divide-by-N.

Top module: `bfp_scale_ctrl`

## Requirements
- R1: After reset, `exp_o`, `exp_final_o` and `shift_o` are all zero.
- R2: The growth of one result is 0 when its value, read as an 18-bit two's-complement number, lies in [-32768, 32767]. It is 1 when the value lies in [-65536, 65535] but outside that range. Otherwise it is 2. `shift_o` never exceeds 2.
- R3: The latched shift is the largest growth over all lanes of all results presented with `res_valid_i` high since the stage began. Data presented while `res_valid_i` is low has no effect.
- R4: `stage_start_i` clears the running maximum, so growth seen before it does not count toward the stage that follows it.
- R5: A stage end is recorded when `stage_end_i` is pulsed. The latch happens on the first clock edge at which a stage end is pending and `pipe_empty_i` is high. Until that edge, `shift_o` and `exp_o` keep their values.
- R6: On the latch edge, `shift_o` takes the stage maximum and `exp_o` increases by that same amount. A stage with no growth leaves the exponent unchanged and sets the shift to 0.
- R7: Each 16-bit lane of `rd_data_o` is the matching 18-bit lane of `rd_raw_i`, shifted right arithmetically by `shift_o` with the low bits dropped, keeping the low 16 bits. This path is combinational.
- R8: A clock edge with `xfm_start_i` high clears the exponent, the shift, the running maximum and any pending stage end. It also captures `xfm_log2n_i` and `xfm_inverse_i`.
- R9: `exp_final_o` equals `exp_o` minus the captured log2N when the captured inverse flag is 1. Otherwise it equals `exp_o`.
- R10: If a result arrives on the latch edge, it counts toward the stage being latched. If `stage_start_i` is high on that same edge, the new stage begins with a maximum of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfm_start_i | input | 1 | Begin a new transform |
| xfm_log2n_i | input | LOGN_W (4) | log2 of the transform length |
| xfm_inverse_i | input | 1 | 1 for an inverse transform |
| stage_start_i | input | 1 | Strobe at the start of a butterfly stage |
| stage_end_i | input | 1 | Strobe at the end of a butterfly stage |
| pipe_empty_i | input | 1 | Butterfly pipeline holds no results |
| res_valid_i | input | 1 | Results on `res_data_i` are valid |
| res_data_i | input | LANES*(WORD_W+2) (72) | Butterfly results with guard bits, lane 0 in the low bits |
| rd_raw_i | input | LANES*(WORD_W+2) (72) | Words fetched from sequence memory |
| rd_data_o | output | LANES*WORD_W (64) | Fetched words after scaling |
| shift_o | output | 2 | Shift applied to the current stage's reads |
| exp_o | output | EXP_W (8) | Common exponent, signed |
| exp_final_o | output | EXP_W (8) | Exponent after the inverse adjustment, signed |

## Verification
Two functions can fall on the same clock edge: latching the finished stage's maximum, and updating the running maximum, either by clearing it for a new stage or by folding in a result. The bench sets this up on purpose. It holds a stage end pending while `pipe_empty_i` is low. It then raises `pipe_empty_i` together with `stage_start_i` and a valid result of growth 2. It checks that the latched shift includes that result, and that the following stage, fed only growth-0 results, latches a shift of 0. Separate random stages check that the latch waits for the drain, and that ignored data and data seen before a stage start leave no trace.

// File: rtl/bfp_pkg.sv
package bfp_pkg;

    // Guard bits carried above the data word by the butterfly results.
    localparam int GUARD_W = 2;
    localparam int SHIFT_W = $clog2(GUARD_W + 1);

    typedef logic [SHIFT_W-1:0] grow_t;

    function automatic grow_t grow_max(input grow_t a, input grow_t b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bfp_growth_lane.sv
module bfp_growth_lane
    import bfp_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W+GUARD_W-1:0] res_i,
    output grow_t                     grow_o
);

    localparam int RES_W = WORD_W + GUARD_W;

    logic uniform;

    // Walk down from the top guard bit. While the bits stay equal to the
    // sign, the value needs one bit of growth fewer.
    always_comb begin
        grow_o  = grow_t'(GUARD_W);
        uniform = 1'b1;
        for (int i = RES_W - 2; i >= WORD_W - 1; i--) begin
            uniform = uniform & (res_i[i] == res_i[RES_W-1]);
            if (uniform) begin
                grow_o = grow_t'(i - (WORD_W - 1));
            end
        end
    end

endmodule

// File: rtl/bfp_growth_max.sv
module bfp_growth_max
    import bfp_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int LANES  = 4
) (
    input  logic                              valid_i,
    input  logic [LANES*(WORD_W+GUARD_W)-1:0] res_i,
    output grow_t                             grow_o
);

    localparam int RES_W = WORD_W + GUARD_W;

    grow_t lane_grow [LANES];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        bfp_growth_lane #(.WORD_W(WORD_W)) u_lane (
            .res_i  (res_i[l*RES_W +: RES_W]),
            .grow_o (lane_grow[l])
        );
    end

    // Invalid cycles contribute nothing to the stage maximum.
    always_comb begin
        grow_o = '0;
        if (valid_i) begin
            for (int l = 0; l < LANES; l++) begin
                grow_o = grow_max(grow_o, lane_grow[l]);
            end
        end
    end

endmodule

// File: rtl/bfp_rd_shift.sv
module bfp_rd_shift
    import bfp_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int LANES  = 4
) (
    input  logic [LANES*(WORD_W+GUARD_W)-1:0] raw_i,
    input  grow_t                             shift_i,
    output logic [LANES*WORD_W-1:0]           data_o
);

    localparam int RES_W = WORD_W + GUARD_W;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic signed [RES_W-1:0] shifted;
        assign shifted = $signed(raw_i[l*RES_W +: RES_W]) >>> shift_i;
        assign data_o[l*WORD_W +: WORD_W] = shifted[WORD_W-1:0];
    end

endmodule

// File: rtl/bfp_scale_ctrl.sv
module bfp_scale_ctrl
    import bfp_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int LANES  = 4,
    parameter int EXP_W  = 8,
    parameter int LOGN_W = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              xfm_start_i,
    input  logic [LOGN_W-1:0]                 xfm_log2n_i,
    input  logic                              xfm_inverse_i,
    input  logic                              stage_start_i,
    input  logic                              stage_end_i,
    input  logic                              pipe_empty_i,
    input  logic                              res_valid_i,
    input  logic [LANES*(WORD_W+GUARD_W)-1:0] res_data_i,
    input  logic [LANES*(WORD_W+GUARD_W)-1:0] rd_raw_i,
    output logic [LANES*WORD_W-1:0]           rd_data_o,
    output logic [SHIFT_W-1:0]                shift_o,
    output logic signed [EXP_W-1:0]           exp_o,
    output logic signed [EXP_W-1:0]           exp_final_o
);

    localparam int RES_W   = WORD_W + GUARD_W;
    localparam int WORD_HI = (1 << (WORD_W - 1)) - 1;
    localparam int WORD_LO = -(1 << (WORD_W - 1));

    typedef struct packed {
        logic signed [EXP_W-1:0] exp;
        grow_t                   shift;
        grow_t                   smax;
        logic                    pend;
        logic [LOGN_W-1:0]       log2n;
        logic                    inv;
    } state_t;

    state_t st_d, st_q;
    grow_t  grow_now;
    grow_t  latch_val;
    logic   end_seen;
    logic   do_latch;

    bfp_growth_max #(.WORD_W(WORD_W), .LANES(LANES)) u_gmax (
        .valid_i (res_valid_i),
        .res_i   (res_data_i),
        .grow_o  (grow_now)
    );

    bfp_rd_shift #(.WORD_W(WORD_W), .LANES(LANES)) u_rdsh (
        .raw_i   (rd_raw_i),
        .shift_i (st_q.shift),
        .data_o  (rd_data_o)
    );

    always_comb begin
        st_d      = st_q;
        end_seen  = st_q.pend | stage_end_i;
        do_latch  = end_seen & pipe_empty_i;
        latch_val = grow_max(st_q.smax, grow_now);
        if (xfm_start_i) begin
            st_d.exp   = '0;
            st_d.shift = '0;
            st_d.smax  = '0;
            st_d.pend  = 1'b0;
            st_d.log2n = xfm_log2n_i;
            st_d.inv   = xfm_inverse_i;
        end else begin
            if (do_latch) begin
                st_d.shift = latch_val;
                st_d.exp   = st_q.exp + EXP_W'(latch_val);
                st_d.pend  = 1'b0;
            end else begin
                st_d.pend  = end_seen;
            end
            if (stage_start_i) begin
                st_d.smax = do_latch ? '0 : grow_now;
            end else begin
                st_d.smax = latch_val;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign shift_o     = st_q.shift;
    assign exp_o       = st_q.exp;
    assign exp_final_o = st_q.inv
                       ? st_q.exp - $signed({{(EXP_W-LOGN_W){1'b0}}, st_q.log2n})
                       : st_q.exp;

    // R2: shift is bounded by the guard width
    assert_shift_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_o <= grow_t'(GUARD_W));

    // R2: a result classed as no growth really fits the word (lane 0)
    assert_grow_zero_fits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_i && grow_now == '0) |->
        ($signed(res_data_i[RES_W-1:0]) >= WORD_LO &&
         $signed(res_data_i[RES_W-1:0]) <= WORD_HI));

    // R5: nothing is latched while the pipeline still holds results
    assert_hold_until_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_empty_i && !xfm_start_i) |=> ($stable(shift_o) && $stable(exp_o)));

    // R8: a transform start clears exponent and shift
    assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        xfm_start_i |=> (exp_o == '0 && shift_o == '0));

    // R9: the adjusted exponent never exceeds the raw exponent
    assert_final_le_raw_R9: assert property (@(posedge clk) disable iff (!rst_n)
        exp_final_o <= exp_o);

endmodule

// File: tb/bfp_scale_ctrl_tb.sv
module bfp_scale_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WORD_W = 16;
    localparam int LANES  = 4;
    localparam int RES_W  = 18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xfm_start = 1'b0;
    logic [3:0] xfm_log2n = '0;
    logic xfm_inverse = 1'b0;
    logic stage_start = 1'b0;
    logic stage_end = 1'b0;
    logic pipe_empty = 1'b1;
    logic res_valid = 1'b0;
    logic [LANES*RES_W-1:0] res_data = '0;
    logic [LANES*RES_W-1:0] rd_raw = '0;
    logic [LANES*WORD_W-1:0] rd_data;
    logic [1:0] shift;
    logic signed [7:0] exp_raw;
    logic signed [7:0] exp_final;

    int checks = 0;
    int errors = 0;
    int exp_m = 0;
    int shift_m = 0;
    int max_m = 0;
    int log2n_m = 0;
    bit inv_m = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bfp_scale_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .xfm_start_i(xfm_start), .xfm_log2n_i(xfm_log2n), .xfm_inverse_i(xfm_inverse),
        .stage_start_i(stage_start), .stage_end_i(stage_end), .pipe_empty_i(pipe_empty),
        .res_valid_i(res_valid), .res_data_i(res_data), .rd_raw_i(rd_raw),
        .rd_data_o(rd_data), .shift_o(shift), .exp_o(exp_raw), .exp_final_o(exp_final)
    );

    function automatic int classify(input int v);
        if (v >= -32768 && v <= 32767) return 0;
        if (v >= -65536 && v <= 65535) return 1;
        return 2;
    endfunction

    function automatic int gen_val(input int cls);
        int mag;
        bit neg;
        neg = $urandom_range(0, 1) == 1;
        case (cls)
            0: return int'($urandom_range(0, 65535)) - 32768;
            1: begin mag = int'($urandom_range(32768, 65535)); return neg ? -mag - 1 : mag; end
            default: begin mag = int'($urandom_range(65536, 131071)); return neg ? -mag - 1 : mag; end
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drives one cycle of results; returns growth folded into model.
    task automatic drive_results(input bit valid, input int maxcls, output int g);
        g = 0;
        res_valid = valid;
        for (int l = 0; l < LANES; l++) begin
            int c;
            int v;
            c = valid ? int'($urandom_range(0, maxcls)) : 2;
            v = gen_val(c);
            if (valid && classify(v) > g) g = classify(v);
            res_data[l*RES_W +: RES_W] = RES_W'(v);
        end
    endtask

    task automatic read_checks(input int n);
        for (int k = 0; k < n; k++) begin
            int vals[LANES];
            @(negedge clk);
            for (int l = 0; l < LANES; l++) begin
                vals[l] = gen_val(int'($urandom_range(0, shift_m)));
                rd_raw[l*RES_W +: RES_W] = RES_W'(vals[l]);
            end
            #1;
            for (int l = 0; l < LANES; l++) begin
                check("R7 read shift", int'($signed(rd_data[l*WORD_W +: WORD_W])),
                      vals[l] >>> shift_m);
            end
        end
    endtask

    task automatic start_xfm(input int l2n, input bit inv);
        @(negedge clk);
        xfm_start = 1'b1; xfm_log2n = 4'(l2n); xfm_inverse = inv;
        @(negedge clk);
        xfm_start = 1'b0;
        exp_m = 0; shift_m = 0; max_m = 0; log2n_m = l2n; inv_m = inv;
        check("R8 start exp", int'(exp_raw), 0);
        check("R8 start shift", int'(shift), 0);
        check("R9 final exp", int'(exp_final), inv ? -l2n : 0);
    endtask

    // One stage: start, results, end held off by a busy pipeline, then latch.
    task automatic run_stage(input int ncyc, input int maxcls);
        int g;
        @(negedge clk);
        stage_start = 1'b1; pipe_empty = 1'b0; res_valid = 1'b0;
        max_m = 0;
        @(negedge clk);
        stage_start = 1'b0;
        for (int c = 0; c < ncyc; c++) begin
            bit v;
            v = $urandom_range(0, 3) != 0;
            drive_results(v, maxcls, g);
            if (g > max_m) max_m = g;
            @(negedge clk);
        end
        res_valid = 1'b0;
        stage_end = 1'b1;
        @(negedge clk);
        stage_end = 1'b0;
        check("R5 hold shift", int'(shift), shift_m);
        @(negedge clk);
        check("R5 hold exp", int'(exp_raw), exp_m);
        pipe_empty = 1'b1;
        @(negedge clk);
        shift_m = max_m;
        exp_m += max_m;
        check("R3 stage max shift", int'(shift), shift_m);
        check("R6 exponent", int'(exp_raw), exp_m);
        check("R9 final exp", int'(exp_final), inv_m ? exp_m - log2n_m : exp_m);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int g;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R1 reset exp", int'(exp_raw), 0);
        check("R1 reset shift", int'(shift), 0);
        check("R1 reset final", int'(exp_final), 0);
        rst_n = 1'b1;

        // Forward transform, random stages
        start_xfm(10, 1'b0);
        for (int s = 0; s < 10; s++) begin
            run_stage(int'($urandom_range(3, 12)), int'($urandom_range(0, 2)));
            read_checks(2);
        end

        // R6: no-growth stage leaves exponent alone and clears shift
        run_stage(6, 0);
        check("R6 no growth shift", int'(shift), 0);

        // R4: growth before a stage start is discarded
        @(negedge clk);
        res_valid = 1'b1;
        for (int l = 0; l < LANES; l++) res_data[l*RES_W +: RES_W] = RES_W'(100000);
        @(negedge clk);
        res_valid = 1'b0;
        run_stage(5, 1);
        check("R4 cleared before stage", int'(shift), max_m);
        check("R4 max not 2", int'(max_m < 2), 1);

        // R10: latch, stage start and a growth-2 result on the same edge
        @(negedge clk);
        stage_start = 1'b1; pipe_empty = 1'b0; max_m = 0;
        @(negedge clk);
        stage_start = 1'b0;
        drive_results(1'b1, 0, g);
        max_m = g;
        @(negedge clk);
        res_valid = 1'b0; stage_end = 1'b1;
        @(negedge clk);
        stage_end = 1'b0;
        @(negedge clk);
        pipe_empty = 1'b1; stage_start = 1'b1; res_valid = 1'b1;
        for (int l = 0; l < LANES; l++) res_data[l*RES_W +: RES_W] = RES_W'(0);
        res_data[2*RES_W +: RES_W] = RES_W'(-131072);
        @(negedge clk);
        stage_start = 1'b0; res_valid = 1'b0; pipe_empty = 1'b0;
        shift_m = 2; exp_m += 2;
        check("R10 latch includes edge result", int'(shift), 2);
        check("R10 exponent", int'(exp_raw), exp_m);
        for (int c = 0; c < 4; c++) begin
            drive_results(1'b1, 0, g);
            @(negedge clk);
        end
        res_valid = 1'b0; stage_end = 1'b1; pipe_empty = 1'b1;
        @(negedge clk);
        stage_end = 1'b0;
        shift_m = 0;
        check("R10 new stage started clear", int'(shift), 0);
        check("R10 exponent kept", int'(exp_raw), exp_m);

        // R3: ignored data while res_valid is low
        @(negedge clk);
        stage_start = 1'b1; pipe_empty = 1'b0;
        @(negedge clk);
        stage_start = 1'b0;
        drive_results(1'b0, 0, g);
        @(negedge clk);
        drive_results(1'b0, 0, g);
        @(negedge clk);
        stage_end = 1'b1; pipe_empty = 1'b1;
        @(negedge clk);
        stage_end = 1'b0;
        check("R3 invalid ignored", int'(shift), 0);

        // R2: single-lane boundary values
        begin
            int bvals[6] = '{32767, -32768, 32768, -32769, 65536, -65537};
            int bexp[6]  = '{0, 0, 1, 1, 2, 2};
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                stage_start = 1'b1; pipe_empty = 1'b0;
                @(negedge clk);
                stage_start = 1'b0; res_valid = 1'b1;
                res_data = '0;
                res_data[3*RES_W +: RES_W] = RES_W'(bvals[k]);
                @(negedge clk);
                res_valid = 1'b0; stage_end = 1'b1; pipe_empty = 1'b1;
                @(negedge clk);
                stage_end = 1'b0;
                exp_m += bexp[k];
                shift_m = bexp[k];
                check("R2 growth class", int'(shift), bexp[k]);
                check("R6 exponent after boundary", int'(exp_raw), exp_m);
            end
            read_checks(3);
        end

        // Inverse transform
        start_xfm(6, 1'b1);
        for (int s = 0; s < 6; s++) begin
            run_stage(int'($urandom_range(3, 8)), 2);
        end

        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule